// File: doc/BRIEF.md
# Threshold Byte FIFO with DMA Request

This block is the byte queue that sits between a host data port and the serial shift registers of an infrared link controller. A single 32-byte store is used in whichever direction the controller is running. When transmitting, the host (or a DMA engine) writes bytes and the transmit shift register takes them from the head. When receiving, the receive shift register pushes bytes and the host (or DMA engine) reads them from the head.

The block reports its fill level and compares it against two programmable thresholds. Each threshold is given as a 4-bit code on a non-linear scale. The comparisons yield a transmit low-water flag and a receive high-water flag. A receive timeout raises a flag when bytes have sat unread for too long. Its length comes from a run-time tick count in the slow (SIR-class) modes and from a build-time constant in the fast (MIR/FIR-class) modes. Both are counted on a divided clock.

A request line drives a DMA handshake. Its assert and release rules depend on the direction. A select input picks the polarities of the request and the acknowledge, or makes the block ignore the acknowledge. While the acknowledge is honoured, host strobes reach the data port whatever the address.

Top module: `ir_byte_fifo`

## Requirements
- R1: The store holds DEPTH (32) bytes. `level` counts the bytes held, from 0 to 32. After reset `level` is 0, and `rx_tout` and `overrun` are 0.
- R2: Bytes leave in the order they entered. A push when the store is full is ignored, and so is a pop when it is empty. A push and a pop that both take effect in one cycle leave `level` unchanged.
- R3: A threshold code c maps to 1 byte when c is 0 and to 2*c bytes otherwise. `tx_low` is 1 exactly when `level` is below the transmit threshold. `rx_high` is 1 exactly when `level` is at or above the receive threshold. Both flags are combinational from `level` and the codes.
- R4: When receiving with DMA enabled, the internal request is set one cycle after `level` reaches the receive threshold or `rx_tout` is 1. It then stays set, even below the threshold, until `level` is 0. It drops in the cycle after `level` becomes 0.
- R5: When transmitting with DMA enabled, the internal request is set one cycle after `level` is below the transmit threshold. It is released one cycle after `level` reaches 32, or after a cycle with `tx_empty_evt` high. Once released it stays off while `level` is at or above the threshold.
- R6: While receiving, `rx_tout` rises exactly L*TICK_DIV cycles after the last push or pop if bytes are still held. L is `slow_to_len` (0 treated as 1) when `fast_mode` is 0, and FAST_TICKS when `fast_mode` is 1. A pop restarts the window.
- R7: `rx_tout` clears on the clock edge that pops a byte. It also clears when the store empties or the direction leaves receive.
- R8: A one-cycle `fifo_clr` empties the store on that edge and clears `rx_tout`. A push or pop in the same cycle is discarded. The threshold codes are inputs and are not affected.
- R9: The internal request is forced off one cycle after `dma_en` is 0. `dma_req` equals the internal request when `dma_sel[0]` is 1 (active high). It equals the inverse of the internal request when `dma_sel[0]` is 0 (active low). With DMA disabled the pin therefore rests at 0 for `dma_sel[0]`=1 and at 1 for `dma_sel[0]`=0.
- R10: The acknowledge counts as active only when `dma_en` is 1 and `dma_sel[1]` is 0. In that case it is active at `dma_ack`=1 if `dma_sel[0]` is 0, and at `dma_ack`=0 if `dma_sel[0]` is 1. An active acknowledge steers host strobes to the data port whatever `host_addr` holds; otherwise the data port is address DATA_ADDR (0). `host_rdata` is the head byte during a data-port read in receive and 0 otherwise.
- R11: A shift-side push while receiving with the store full (and no pop in the same cycle) is dropped. `overrun` is then 1 for exactly the following cycle, and the stored bytes are unchanged.
- R12: In transmit (`dir_rx`=0) only host writes push and only `sr_pop` pops. In receive (`dir_rx`=1) only `sr_push` pushes and only host reads pop. Strobes on the other side are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_rx | input | 1 | 1 = receive direction, 0 = transmit direction |
| fast_mode | input | 1 | 1 = MIR/FIR-class timeout, 0 = SIR-class timeout |
| slow_to_len | input | LEN_W | Slow-mode timeout length in prescaled ticks |
| tx_code | input | 4 | Transmit threshold code |
| rx_code | input | 4 | Receive threshold code |
| fifo_clr | input | 1 | One-cycle strobe that empties the store |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | WIDTH | Host write byte |
| host_rdata | output | WIDTH | Head byte on a data-port read, else 0 |
| sr_push | input | 1 | Receive shift register delivers a byte |
| sr_wdata | input | WIDTH | Byte from the receive shift register |
| sr_pop | input | 1 | Transmit shift register takes the head byte |
| sr_rdata | output | WIDTH | Head byte for the transmit shift register (0 when empty) |
| tx_empty_evt | input | 1 | Transmit-empty event pulse |
| dma_en | input | 1 | Enables the DMA request |
| dma_sel | input | 2 | Bit 0 request/acknowledge polarity, bit 1 ignore acknowledge |
| dma_ack | input | 1 | DMA acknowledge pin |
| dma_req | output | 1 | DMA request pin |
| level | output | LW | Bytes held |
| tx_low | output | 1 | Level below transmit threshold |
| rx_high | output | 1 | Level at or above receive threshold |
| rx_tout | output | 1 | Receive timeout flag |
| overrun | output | 1 | One-cycle pulse on a dropped receive byte |

## Verification
A pointer or count that drifts shows up on `level` at the very next edge. It shows up on `sr_rdata` or `host_rdata` as a wrong byte on the next pop, so the order checks catch it within one transfer. A request register stuck in the wrong state is visible on `dma_req` one cycle after the level crosses a threshold. The hold-below-threshold and release-on-full cases expose a request that tracks the comparator instead of latching. A timer that starts, restarts or divides wrongly moves the rising edge of `rx_tout` by at least one cycle, and the bench samples the cycle before and the cycle of the expected edge.

// File: rtl/ir_fifo_pkg.sv
package ir_fifo_pkg;

  localparam int CODE_W = 4;

  // Threshold code to byte count: 0 -> 1, otherwise twice the code.
  function automatic int unsigned thr_bytes(input logic [CODE_W-1:0] code);
    return (code == '0) ? 32'd1 : {27'd0, code, 1'b0};
  endfunction

  // Request pin level from the internal request and the polarity bit.
  function automatic logic req_pin(input logic req, input logic active_high);
    return active_high ? req : ~req;
  endfunction

  // Acknowledge decode: polarity is the opposite of the request's.
  function automatic logic ack_live(input logic en, input logic [1:0] sel, input logic pin);
    return en && !sel[1] && (sel[0] ? !pin : pin);
  endfunction

endpackage

// File: rtl/ir_fifo_mem.sv
module ir_fifo_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    count,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = !clr && pop_req && (count != '0);
  assign push_ok = !clr && push_req && ((count != LW'(DEPTH)) || pop_ok);
  assign head    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ir_rx_timer.sv
module ir_rx_timer #(
  parameter int TICK_DIV   = 48,
  parameter int FAST_TICKS = 69500,
  parameter int LEN_W      = 16,
  localparam int MAXT = (FAST_TICKS > (1 << LEN_W)) ? FAST_TICKS : (1 << LEN_W),
  localparam int CW   = $clog2(MAXT + 1),
  localparam int DW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rx_on,
  input  logic             has_data,
  input  logic             push_evt,
  input  logic             pop_evt,
  input  logic             fast_mode,
  input  logic [LEN_W-1:0] slow_len,
  output logic             tout
);

  logic [DW-1:0] pdiv;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] limit;
  logic          tick;
  logic          restart;
  logic          drop;

  // Window length in prescaled ticks; a zero slow length acts as one tick.
  function automatic logic [CW-1:0] window(input logic fast, input logic [LEN_W-1:0] slen);
    if (fast)        return CW'(FAST_TICKS);
    if (slen == '0)  return CW'(1);
    return CW'(slen);
  endfunction

  assign limit   = window(fast_mode, slow_len);
  assign tick    = (pdiv == DW'(TICK_DIV - 1));
  assign drop    = clr || !rx_on || pop_evt || !has_data;
  assign restart = drop || push_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv <= '0;
      tcnt <= '0;
      tout <= 1'b0;
    end else if (restart) begin
      pdiv <= '0;
      tcnt <= '0;
      if (drop) tout <= 1'b0;
    end else if (!tout) begin
      if (tick) begin
        pdiv <= '0;
        tcnt <= tcnt + 1'b1;
        if (tcnt == limit - 1'b1) tout <= 1'b1;
      end else begin
        pdiv <= pdiv + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ir_dma_req.sv
module ir_dma_req #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          dir_rx,
  input  logic [LW-1:0] level,
  input  logic [3:0]    tx_code,
  input  logic [3:0]    rx_code,
  input  logic          tout,
  input  logic          tx_empty_evt,
  output logic          tx_low,
  output logic          rx_high,
  output logic          req
);
  import ir_fifo_pkg::*;

  logic req_d;
  logic dir_q;
  logic full;
  logic empty;

  assign tx_low  = 32'(level) <  thr_bytes(tx_code);
  assign rx_high = 32'(level) >= thr_bytes(rx_code);
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);

  always_comb begin
    if (dir_rx) req_d = (req || rx_high || tout) && !empty;
    else if (req) req_d = !(full || tx_empty_evt);
    else req_d = tx_low && !tx_empty_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      dir_q <= dir_rx;
      if (!dma_en || (dir_rx != dir_q)) req <= 1'b0;
      else req <= req_d;
    end
  end

endmodule

// File: rtl/ir_byte_fifo.sv
module ir_byte_fifo #(
  parameter int DEPTH      = 32,
  parameter int WIDTH      = 8,
  parameter int ADDR_W     = 4,
  parameter int DATA_ADDR  = 0,
  parameter int TICK_DIV   = 48,
  parameter int FAST_TICKS = 69500,
  parameter int LEN_W      = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_rx,
  input  logic              fast_mode,
  input  logic [LEN_W-1:0]  slow_to_len,
  input  logic [3:0]        tx_code,
  input  logic [3:0]        rx_code,
  input  logic              fifo_clr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WIDTH-1:0]  host_wdata,
  output logic [WIDTH-1:0]  host_rdata,
  input  logic              sr_push,
  input  logic [WIDTH-1:0]  sr_wdata,
  input  logic              sr_pop,
  output logic [WIDTH-1:0]  sr_rdata,
  input  logic              tx_empty_evt,
  input  logic              dma_en,
  input  logic [1:0]        dma_sel,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic [LW-1:0]     level,
  output logic              tx_low,
  output logic              rx_high,
  output logic              rx_tout,
  output logic              overrun
);
  import ir_fifo_pkg::*;

  logic             ack_on;
  logic             data_hit;
  logic             host_push;
  logic             host_pop;
  logic             push_req;
  logic             pop_req;
  logic [WIDTH-1:0] push_data;
  logic [WIDTH-1:0] head;
  logic             push_ok;
  logic             pop_ok;
  logic             req_act;
  logic             ovr_q;
  logic             full;

  assign ack_on    = ack_live(dma_en, dma_sel, dma_ack);
  assign data_hit  = ack_on || (host_addr == ADDR_W'(DATA_ADDR));
  assign host_push = host_wr && data_hit && !dir_rx;
  assign host_pop  = host_rd && data_hit && dir_rx;
  assign push_req  = dir_rx ? sr_push : host_push;
  assign push_data = dir_rx ? sr_wdata : host_wdata;
  assign pop_req   = dir_rx ? host_pop : sr_pop;
  assign full      = (level == LW'(DEPTH));

  ir_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (fifo_clr),
    .push_req (push_req),
    .push_data(push_data),
    .pop_req  (pop_req),
    .head     (head),
    .count    (level),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok)
  );

  ir_rx_timer #(.TICK_DIV(TICK_DIV), .FAST_TICKS(FAST_TICKS), .LEN_W(LEN_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (fifo_clr),
    .rx_on    (dir_rx),
    .has_data (level != '0),
    .push_evt (push_ok),
    .pop_evt  (pop_ok),
    .fast_mode(fast_mode),
    .slow_len (slow_to_len),
    .tout     (rx_tout)
  );

  ir_dma_req #(.DEPTH(DEPTH)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_en      (dma_en),
    .dir_rx      (dir_rx),
    .level       (level),
    .tx_code     (tx_code),
    .rx_code     (rx_code),
    .tout        (rx_tout),
    .tx_empty_evt(tx_empty_evt),
    .tx_low      (tx_low),
    .rx_high     (rx_high),
    .req         (req_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else ovr_q <= dir_rx && sr_push && !fifo_clr && full && !pop_ok;
  end

  assign overrun    = ovr_q;
  assign dma_req    = req_pin(req_act, dma_sel[0]);
  assign host_rdata = host_pop ? head : '0;
  assign sr_rdata   = (level != '0) ? head : '0;

endmodule

// File: rtl/ir_byte_fifo_chk.sv
module ir_byte_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] level,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          fifo_clr,
  input logic          dma_en,
  input logic          req_act,
  input logic          overrun,
  input logic          rx_tout
);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_both_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (level == $past(level)));

  p_full_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((level == LW'(DEPTH)) && !pop_ok) |-> !push_ok);

  p_empty_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !pop_ok);

  p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (level == '0));

  p_dma_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !req_act);

  p_overrun_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(level) == LW'(DEPTH)));

  p_tout_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tout |-> (level != '0));

endmodule

bind ir_byte_fifo ir_byte_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .level   (level),
  .push_ok (push_ok),
  .pop_ok  (pop_ok),
  .fifo_clr(fifo_clr),
  .dma_en  (dma_en),
  .req_act (req_act),
  .overrun (overrun),
  .rx_tout (rx_tout)
);

// File: tb/sim_ir_byte_fifo.sv
module sim_ir_byte_fifo;

  localparam int DEPTH = 32;
  localparam int DIV   = 2;
  localparam int FAST  = 10;
  localparam int LENW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_rx = 1'b0, fast_mode = 1'b0;
  logic [LENW-1:0] slow_to_len = 8'd4;
  logic [3:0] tx_code = 4'd7, rx_code = 4'd7;
  logic fifo_clr = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'd0, sr_wdata = 8'd0;
  logic [7:0] host_rdata, sr_rdata;
  logic sr_push = 1'b0, sr_pop = 1'b0, tx_empty_evt = 1'b0;
  logic dma_en = 1'b0, dma_ack = 1'b0;
  logic [1:0] dma_sel = 2'b00;
  logic dma_req, tx_low, rx_high, rx_tout, overrun;
  logic [5:0] level;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;

  always #4 clk = ~clk;

  ir_byte_fifo #(.DEPTH(DEPTH), .TICK_DIV(DIV), .FAST_TICKS(FAST), .LEN_W(LENW)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .fast_mode(fast_mode),
    .slow_to_len(slow_to_len), .tx_code(tx_code), .rx_code(rx_code),
    .fifo_clr(fifo_clr), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sr_push(sr_push), .sr_wdata(sr_wdata), .sr_pop(sr_pop), .sr_rdata(sr_rdata),
    .tx_empty_evt(tx_empty_evt), .dma_en(dma_en), .dma_sel(dma_sel),
    .dma_ack(dma_ack), .dma_req(dma_req), .level(level), .tx_low(tx_low),
    .rx_high(rx_high), .rx_tout(rx_tout), .overrun(overrun)
  );

  function automatic int exp_thr(int c);
    if (c == 0) return 1;
    return c + c;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cycs(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic host_write(int a, int d);
    host_addr = 4'(a); host_wdata = 8'(d); host_wr = 1'b1;
    cyc();
    host_wr = 1'b0;
  endtask

  task automatic host_read(int a, output int d);
    host_addr = 4'(a); host_rd = 1'b1;
    #1 d = int'(host_rdata);
    cyc();
    host_rd = 1'b0;
  endtask

  task automatic sr_in(int d);
    sr_wdata = 8'(d); sr_push = 1'b1;
    cyc();
    sr_push = 1'b0;
  endtask

  task automatic sr_out(output int d);
    #1 d = int'(sr_rdata);
    sr_pop = 1'b1;
    cyc();
    sr_pop = 1'b0;
  endtask

  task automatic clear_all();
    fifo_clr = 1'b1;
    cyc();
    fifo_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int d;
    cycs(3);
    rst_n = 1'b1;
    cyc();
    // R1 reset state, R9 idle request level (active low select)
    check("R1 reset level", level, 0);
    check("R1 reset tout", rx_tout, 0);
    check("R1 reset overrun", overrun, 0);
    check("R9 reset dma_req", dma_req, 1);

    // Fill sweep in transmit: level, threshold decode over every code
    for (int i = 0; i <= DEPTH; i++) begin
      check("R1 level during fill", level, i);
      for (int c = 0; c < 16; c++) begin
        tx_code = 4'(c); rx_code = 4'(c);
        #1;
        check("R3 tx_low", tx_low, (i < exp_thr(c)) ? 1 : 0);
        check("R3 rx_high", rx_high, (i >= exp_thr(c)) ? 1 : 0);
      end
      @(negedge clk);
      if (i < DEPTH) host_write(0, (i * 7 + 3) & 255);
    end
    host_write(0, 8'hEE);
    check("R2 push when full ignored", level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      sr_out(d);
      check("R2 order", d, (i * 7 + 3) & 255);
      check("R2 level on drain", level, DEPTH - 1 - i);
    end
    sr_out(d);
    check("R2 pop when empty ignored", level, 0);

    // R2 simultaneous push and pop
    for (int i = 0; i < 5; i++) host_write(0, 10 + i);
    host_wdata = 8'd99; host_addr = 4'd0; host_wr = 1'b1; sr_pop = 1'b1;
    #1 d = int'(sr_rdata);
    cyc();
    host_wr = 1'b0; sr_pop = 1'b0;
    check("R2 push+pop head", d, 10);
    check("R2 push+pop level", level, 5);
    // R8 clear wins over a push in the same cycle
    fifo_clr = 1'b1; host_wr = 1'b1; host_wdata = 8'd1;
    cyc();
    fifo_clr = 1'b0; host_wr = 1'b0;
    check("R8 clear empties", level, 0);

    // R12 direction gating
    sr_in(5);
    check("R12 sr_push ignored in transmit", level, 0);
    host_write(0, 8'h31);
    host_read(0, d);
    check("R12 host read ignored in transmit", level, 1);
    check("R12 rdata zero in transmit", d, 0);
    dir_rx = 1'b1;
    cyc();
    host_write(0, 8'h32);
    check("R12 host write ignored in receive", level, 1);
    sr_out(d);
    check("R12 sr_pop ignored in receive", level, 1);
    clear_all();

    // R4 receive request, active-high pin
    dma_en = 1'b1; dma_sel = 2'b01; dma_ack = 1'b1; rx_code = 4'd1; slow_to_len = 8'd200;
    cyc();
    check("R4 idle request", dma_req, 0);
    sr_in(1);
    check("R4 below threshold", dma_req, 0);
    sr_in(2);
    check("R4 request registered", dma_req, 0);
    cyc();
    check("R4 request at threshold", dma_req, 1);
    host_read(0, d);
    check("R4 read data", d, 1);
    check("R4 hold below threshold", dma_req, 1);
    host_read(0, d);
    check("R4 last byte data", d, 2);
    check("R4 still set on emptying edge", dma_req, 1);
    cyc();
    check("R4 released when empty", dma_req, 0);

    // R6/R7 slow timeout: 4 ticks of 2 cycles
    rx_code = 4'd15; slow_to_len = 8'd4; fast_mode = 1'b0;
    sr_in(8'h55);
    cycs(4 * DIV - 1);
    check("R6 slow before edge", rx_tout, 0);
    cyc();
    check("R6 slow edge", rx_tout, 1);
    cyc();
    check("R4 timeout request", dma_req, 1);
    host_read(0, d);
    check("R7 read clears timeout", rx_tout, 0);
    cyc();
    check("R4 timeout request released", dma_req, 0);

    // R6/R7 fast timeout and restart by a read
    fast_mode = 1'b1;
    sr_in(8'h61);
    sr_in(8'h62);
    cycs(FAST * DIV - 1);
    check("R6 fast before edge", rx_tout, 0);
    cyc();
    check("R6 fast edge", rx_tout, 1);
    host_read(0, d);
    check("R7 read clears fast timeout", rx_tout, 0);
    check("R7 level after read", level, 1);
    cycs(FAST * DIV - 1);
    check("R6 restart before edge", rx_tout, 0);
    cyc();
    check("R6 restart edge", rx_tout, 1);
    clear_all();
    check("R8 clear drops timeout", rx_tout, 0);
    check("R8 clear level", level, 0);
    fast_mode = 1'b0; slow_to_len = 8'd200;

    // R9 disable and polarity
    dma_en = 1'b0; dma_sel = 2'b01; rx_code = 4'd0;
    sr_in(1);
    cycs(2);
    check("R9 disabled active-high rests low", dma_req, 0);
    dma_sel = 2'b00; dma_ack = 1'b0;
    cyc();
    check("R9 disabled active-low rests high", dma_req, 1);
    dma_en = 1'b1;
    cycs(2);
    check("R9 enabled active-low asserted", dma_req, 0);
    clear_all();

    // R10 acknowledge steering
    sr_in(8'h21);
    sr_in(8'h22);
    host_read(5, d);
    check("R10 no ack, other address", d, 0);
    check("R10 no ack level", level, 2);
    dma_ack = 1'b1;
    host_read(5, d);
    check("R10 active-high ack data", d, 8'h21);
    check("R10 active-high ack level", level, 1);
    dma_sel = 2'b01; dma_ack = 1'b0;
    host_read(9, d);
    check("R10 active-low ack data", d, 8'h22);
    check("R10 active-low ack level", level, 0);
    sr_in(8'h23);
    dma_sel = 2'b10; dma_ack = 1'b1;
    host_read(5, d);
    check("R10 ack ignored high", d, 0);
    dma_ack = 1'b0;
    host_read(5, d);
    check("R10 ack ignored low", d, 0);
    check("R10 ack ignored level", level, 1);
    clear_all();

    // R5 transmit request, active-low pin
    dir_rx = 1'b0; dma_sel = 2'b00; dma_ack = 1'b0; tx_code = 4'd1;
    cycs(2);
    check("R5 asserted when empty", dma_req, 0);
    for (int i = 0; i < DEPTH; i++) host_write(0, i);
    check("R5 still asserted at full edge", dma_req, 0);
    check("R5 level full", level, DEPTH);
    cyc();
    check("R5 released on full", dma_req, 1);
    for (int i = 0; i < DEPTH - 2; i++) sr_out(d);
    cyc();
    check("R5 stays off at threshold", dma_req, 1);
    sr_out(d);
    check("R5 one cycle lag", dma_req, 1);
    cyc();
    check("R5 reasserted below threshold", dma_req, 0);
    tx_empty_evt = 1'b1;
    cyc();
    tx_empty_evt = 1'b0;
    check("R5 released by empty event", dma_req, 1);
    cyc();
    check("R5 reasserted after event", dma_req, 0);
    clear_all();

    // R11 overrun
    dir_rx = 1'b1; dma_en = 1'b0;
    cyc();
    for (int i = 0; i < DEPTH; i++) sr_in(40 + i);
    check("R11 no overrun when filling", overrun, 0);
    sr_in(8'h99);
    check("R11 level held", level, DEPTH);
    check("R11 overrun pulse", overrun, 1);
    cyc();
    check("R11 pulse one cycle", overrun, 0);
    host_read(0, d);
    check("R11 stored bytes unchanged", d, 40);
    clear_all();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule